// File: doc/BRIEF.md
# Bus-Mapped Timer/Counter with Atomic 16-bit Access

This block is a free-running counter, 8 or 16 bits wide, that sits on a small byte-wide register bus. It counts one of two sources. In timer mode it counts the instruction-rate tick, which is one pulse every four system clocks. In counter mode it counts edges on an external pin. The pin is first brought into the system clock domain through a two-flop synchroniser, and a control bit picks the active edge. A programmable power-of-two prescaler can be switched into the path between the source and the counter.

The counter's upper byte is never reached directly. Reading the low byte copies the live upper byte into a one-byte buffer in the same cycle, so a following read of the buffer always matches that low byte. Writing the buffer only stages a value. The next low-byte write loads the staged upper byte and the new low byte into the counter together. After any low-byte write, the next two instruction ticks are swallowed. When the counter wraps from all ones to zero, an overflow flag is set and drives an interrupt line. The flag holds until software clears it.

Register map, by 2-bit address: 0 = control, 1 = counter low byte, 2 = high-byte buffer, 3 = status (bit 0 = overflow flag). Control bits: 7 = run, 6 = narrow (1 selects 8-bit mode), 5 = source (1 selects the external pin), 4 = edge (1 selects falling edges), 3 = prescaler in path, 2:0 = prescaler select.

Top module: `shadow_timer`

## Requirements
- R1: After reset, control reads 0xFF (running, 8-bit, pin source, falling edge, prescaler in path at select 7). The low byte, the buffer and the status register all read 0.
- R2: In timer mode (control bit 5 = 0) with the prescaler out of the path, the counter advances by exactly one for every four system clocks.
- R3: In counter mode, control bit 4 = 0 counts only rising pin edges, and bit 4 = 1 counts only falling pin edges.
- R4: A pin transition that occurs before rising clock edge k changes the counter at rising edge k+2 and not before.
- R5: With control bit 3 = 1 and select value s, the counter advances once per 2^(s+1) source events. The prescaler count is cleared by every low-byte write.
- R6: A low-byte write of value v is followed by exactly two ignored instruction ticks. In timer mode without the prescaler, the count 4k clocks after the write is v+k-2, for k of 2 or more.
- R7: In 16-bit mode, a read of address 1 copies the live upper byte into the buffer in that cycle. Address 2 reads the buffer.
- R8: A write to address 2 changes only the buffer. A write to address 1 loads {buffer, data} in 16-bit mode, but only the low byte in 8-bit mode.
- R9: An increment from 0xFF in 8-bit mode, or from 0xFFFF in 16-bit mode, wraps the active width to zero and sets the overflow flag. The flag drives `ovf_irq`.
- R10: Writing 0 to status bit 0 clears the flag and writing 1 leaves it unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R11: With control bit 7 = 0, the counter holds its value whatever the source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cnt_pin | input | 1 | External count input, asynchronous |
| ovf_irq | output | 1 | Overflow flag |

## Verification
The bench loads staged 16-bit values and reads them back through the buffer. A design that let a buffer write reach the counter, or that skipped the copy on a low read, would return a stale or staged upper byte. Timer deltas are measured over exact clock windows after a low-byte write. A missing or one-cycle-short inhibit shows up as a count of v+k or v+k-1, and a prescaler that is not cleared or uses the wrong ratio gives a wrong quotient. The pin latency is sampled clock by clock, and edge patterns with unequal rising and falling counts show up a swapped edge select. A status clear is driven in the same cycle as a wrap, so a design that lets the clear win would show the flag at 0.

// File: rtl/shtmr_pkg.sv
package shtmr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOW  = 2'd1,
    REG_HIGH = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       run;
    logic       narrow;
    logic       ext_src;
    logic       fall_edge;
    logic       pre_on;
    logic [2:0] pre_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = ctrl_t'(8'hFF);
endpackage

// File: rtl/shtmr_cycle_tick.sv
module shtmr_cycle_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase_q, phase_d;

  assign tick_o = (phase_q == PW'(DIV - 1));

  always_comb begin
    if (tick_o) phase_d = '0;
    else        phase_d = phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/shtmr_edge_sync.sv
module shtmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic pulse_o
);
  logic [STAGES:0] sh_q, sh_d;
  logic cur, prev;

  always_comb sh_d = {sh_q[STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign cur  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];

  always_comb begin
    if (fall_sel_i) pulse_o = prev & ~cur;
    else            pulse_o = cur & ~prev;
  end
endmodule

// File: rtl/shtmr_prescale.sv
module shtmr_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             inc_o
);
  localparam int CW = 1 << SEL_W;

  logic [CW-1:0] pcnt_q, pcnt_d, mask;
  logic          wrap;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CW; i++) begin
      if (i <= int'(sel_i)) mask[i] = 1'b1;
    end
  end

  assign wrap = ((pcnt_q & mask) == mask);

  always_comb begin
    if (en_i) inc_o = src_i & wrap;
    else      inc_o = src_i;
  end

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr_i)              pcnt_d = '0;
    else if (src_i && en_i) pcnt_d = pcnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/shtmr_core.sv
module shtmr_core #(
  parameter int BYTE_W  = 8,
  parameter int INH_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                inc_i,
  input  logic                narrow_i,
  input  logic                wr_low_i,
  input  logic                wr_high_i,
  input  logic                rd_low_i,
  input  logic                clr_flag_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [2*BYTE_W-1:0] count_o,
  output logic [BYTE_W-1:0]   hibuf_o,
  output logic                flag_o,
  output logic                ready_o,
  output logic                ovf_evt_o
);
  localparam int CW = 2 * BYTE_W;
  localparam int IW = $clog2(INH_CYC + 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] hib_q, hib_d;
  logic [IW-1:0]     inh_q, inh_d;
  logic              flag_q, flag_d;
  logic              at_max;

  assign at_max    = narrow_i ? (&cnt_q[BYTE_W-1:0]) : (&cnt_q);
  assign ovf_evt_o = inc_i & at_max & ~wr_low_i;
  assign ready_o   = (inh_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_low_i) begin
      if (narrow_i) cnt_d = {cnt_q[CW-1:BYTE_W], wdata_i};
      else          cnt_d = {hib_q, wdata_i};
    end else if (inc_i) begin
      if (narrow_i) cnt_d = {cnt_q[CW-1:BYTE_W], cnt_q[BYTE_W-1:0] + BYTE_W'(1)};
      else          cnt_d = cnt_q + CW'(1);
    end
  end

  always_comb begin
    hib_d = hib_q;
    if (wr_high_i)                hib_d = wdata_i;
    else if (rd_low_i && !narrow_i) hib_d = cnt_q[CW-1:BYTE_W];
  end

  always_comb begin
    inh_d = inh_q;
    if (wr_low_i)                  inh_d = IW'(INH_CYC);
    else if (tick_i && !ready_o)   inh_d = inh_q - IW'(1);
  end

  always_comb begin
    flag_d = flag_q;
    if (ovf_evt_o)       flag_d = 1'b1;
    else if (clr_flag_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hib_q  <= '0;
      inh_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hib_q  <= hib_d;
      inh_q  <= inh_d;
      flag_q <= flag_d;
    end
  end

  assign count_o = cnt_q;
  assign hibuf_o = hib_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/shadow_timer.sv
module shadow_timer
  import shtmr_pkg::*;
#(
  parameter int CYC_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int INH_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cnt_pin,
  output logic              ovf_irq
);
  localparam int CW = 2 * BYTE_W;

  ctrl_t             ctrl_q, ctrl_d;
  reg_sel_e          sel;
  logic              wr_ctrl, wr_low, wr_high, wr_stat, rd_low, clr_flag;
  logic              tick, edge_pulse, src_sel, src_gated, inc;
  logic              ready, ovf_evt, ovf_flag, narrow, run;
  logic [CW-1:0]     cnt_val;
  logic [BYTE_W-1:0] hib_val;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_ctrl  = bus_wr && (sel == REG_CTRL);
  assign wr_low   = bus_wr && (sel == REG_LOW);
  assign wr_high  = bus_wr && (sel == REG_HIGH);
  assign wr_stat  = bus_wr && (sel == REG_STAT);
  assign rd_low   = bus_rd && !bus_wr && (sel == REG_LOW);
  assign clr_flag = wr_stat && !bus_wdata[0];
  assign narrow   = ctrl_q.narrow;
  assign run      = ctrl_q.run;

  always_comb begin
    if (wr_ctrl) ctrl_d = ctrl_t'(bus_wdata);
    else         ctrl_d = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  shtmr_cycle_tick #(.DIV(CYC_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  shtmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (cnt_pin),
    .fall_sel_i (ctrl_q.fall_edge),
    .pulse_o    (edge_pulse)
  );

  assign src_sel   = ctrl_q.ext_src ? edge_pulse : tick;
  assign src_gated = run & ready & src_sel;

  shtmr_prescale #(.SEL_W(3)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_gated),
    .en_i  (ctrl_q.pre_on),
    .sel_i (ctrl_q.pre_sel),
    .clr_i (wr_low),
    .inc_o (inc)
  );

  shtmr_core #(.BYTE_W(BYTE_W), .INH_CYC(INH_CYC)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .inc_i      (inc),
    .narrow_i   (narrow),
    .wr_low_i   (wr_low),
    .wr_high_i  (wr_high),
    .rd_low_i   (rd_low),
    .clr_flag_i (clr_flag),
    .wdata_i    (bus_wdata),
    .count_o    (cnt_val),
    .hibuf_o    (hib_val),
    .flag_o     (ovf_flag),
    .ready_o    (ready),
    .ovf_evt_o  (ovf_evt)
  );

  always_comb begin
    case (sel)
      REG_CTRL: bus_rdata = ctrl_q;
      REG_LOW:  bus_rdata = cnt_val[BYTE_W-1:0];
      REG_HIGH: bus_rdata = hib_val;
      default:  bus_rdata = {{(BYTE_W-1){1'b0}}, ovf_flag};
    endcase
  end

  assign ovf_irq = ovf_flag;
endmodule

// File: rtl/shtmr_checker.sv
module shtmr_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*BYTE_W-1:0] cnt,
  input logic [BYTE_W-1:0]   hibuf,
  input logic                flag,
  input logic                inc,
  input logic                ready,
  input logic                wr_low,
  input logic                wr_high,
  input logic                rd_low,
  input logic                clr,
  input logic                ovf_evt,
  input logic                narrow,
  input logic                run,
  input logic                pulse
);
  logic at_max;
  assign at_max = narrow ? (&cnt[BYTE_W-1:0]) : (&cnt);

  // R9: the flag only rises after an increment from all ones
  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(inc && at_max && !wr_low));

  // R9: a 16-bit increment advances the full counter by one
  assert_wide_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_low && !narrow) |=> cnt == $past(cnt) + (2*BYTE_W)'(1));

  // R8: a buffer write leaves the counter alone
  assert_high_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_high && !inc) |=> cnt == $past(cnt));

  // R7: a 16-bit low read captures the live upper byte
  assert_low_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_low && !narrow && !wr_high) |=> hibuf == $past(cnt[2*BYTE_W-1:BYTE_W]));

  // R6: while inhibited and not written, the count is frozen
  assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !wr_low) |=> cnt == $past(cnt));

  // R10: overflow wins over a clear in the same cycle
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag);

  // R10: a clear with no overflow drops the flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ovf_evt) |=> !flag);

  // R11: stopped counter holds
  assert_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_low) |=> cnt == $past(cnt));

  // R4: at most one edge pulse in a row
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

bind shadow_timer shtmr_checker #(.BYTE_W(shtmr_pkg::BYTE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt     (cnt_val),
  .hibuf   (hib_val),
  .flag    (ovf_flag),
  .inc     (inc),
  .ready   (ready),
  .wr_low  (wr_low),
  .wr_high (wr_high),
  .rd_low  (rd_low),
  .clr     (clr_flag),
  .ovf_evt (ovf_evt),
  .narrow  (narrow),
  .run     (run),
  .pulse   (edge_pulse)
);

// File: tb/shadow_timer_test.sv
module shadow_timer_test;
  localparam logic [1:0] A_CTRL = 2'd0, A_LOW = 2'd1, A_HIGH = 2'd2, A_STAT = 2'd3;
  localparam logic [7:0] C_RUN = 8'h80, C_NAR = 8'h40, C_EXT = 8'h20, C_FALL = 8'h10, C_PRE = 8'h08;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd, cnt_pin;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ovf_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shadow_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_pin = 1'b1;
      repeat (3) @(negedge clk);
      cnt_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  function automatic int prescaled(input int n, input int sel);
    return n >> (sel + 1);
  endfunction

  function automatic int after_inhibit(input int v, input int k);
    return (v + k - 2) & 8'hFF;
  endfunction

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] d, h, l;
    int n, sel, k, v, a, b, seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; cnt_pin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 8'hFF);
    rd(A_LOW, d);  chk("R1 low", d, 0);
    rd(A_HIGH, d); chk("R1 high", d, 0);
    rd(A_STAT, d); chk("R1 stat", d, 0);

    // R4 synchroniser latency
    wr(A_CTRL, C_RUN | C_NAR | C_EXT);
    wr(A_LOW, 8'h00); settle();
    @(negedge clk); cnt_pin = 1'b1; bus_addr = A_LOW;
    @(negedge clk); chk("R4 edge k", bus_rdata, 0);
    @(negedge clk); chk("R4 edge k+1", bus_rdata, 0);
    @(negedge clk); chk("R4 edge k+2", bus_rdata, 1);
    cnt_pin = 1'b0; repeat (4) @(negedge clk);

    // R3 rising then falling selection
    for (int it = 0; it < 3; it++) begin
      n = $urandom_range(2, 9);
      wr(A_CTRL, C_RUN | C_NAR | C_EXT);
      wr(A_LOW, 8'h00); settle();
      pin_pulses(n);
      @(negedge clk); cnt_pin = 1'b1; repeat (5) @(negedge clk);
      rd(A_LOW, d); chk("R3 rising", d, n + 1);
      cnt_pin = 1'b0; repeat (5) @(negedge clk);
      rd(A_LOW, d); chk("R3 rising ignores fall", d, n + 1);
      wr(A_CTRL, C_RUN | C_NAR | C_EXT | C_FALL);
      wr(A_LOW, 8'h00); settle();
      pin_pulses(n);
      @(negedge clk); cnt_pin = 1'b1; repeat (5) @(negedge clk);
      rd(A_LOW, d); chk("R3 falling ignores rise", d, n);
      cnt_pin = 1'b0; repeat (5) @(negedge clk);
      rd(A_LOW, d); chk("R3 falling", d, n + 1);
    end

    // R5 prescaler in counter mode, cleared by low write
    for (int it = 0; it < 4; it++) begin
      sel = $urandom_range(0, 2);
      n = $urandom_range(0, 20);
      wr(A_CTRL, C_RUN | C_NAR | C_EXT | C_PRE | 8'(sel));
      pin_pulses(1);
      wr(A_LOW, 8'h00); settle();
      pin_pulses(n);
      rd(A_LOW, d); chk("R5 pin prescale", d, prescaled(n, sel));
    end

    // R2 timer rate, R5 timer prescale
    for (int it = 0; it < 5; it++) begin
      sel = (it == 4) ? 7 : $urandom_range(0, 3);
      k = $urandom_range(1, 4);
      if (it == 0) wr(A_CTRL, C_RUN | C_NAR);
      else         wr(A_CTRL, C_RUN | C_NAR | C_PRE | 8'(sel));
      wr(A_LOW, 8'h00); settle();
      bus_addr = A_LOW;
      @(negedge clk); a = bus_rdata;
      if (it == 0) begin
        repeat (4 * k) @(negedge clk);
        b = bus_rdata; chk("R2 timer rate", (b - a) & 8'hFF, k);
      end else begin
        repeat (4 * k * (1 << (sel + 1))) @(negedge clk);
        b = bus_rdata; chk("R5 timer prescale", (b - a) & 8'hFF, k);
      end
    end

    // R6 post-write inhibit
    for (int it = 0; it < 4; it++) begin
      v = $urandom_range(0, 200);
      k = $urandom_range(2, 10);
      wr(A_CTRL, C_RUN | C_NAR);
      wr(A_LOW, 8'(v));
      bus_addr = A_LOW;
      repeat (4 * k) @(negedge clk);
      chk("R6 inhibit", bus_rdata, after_inhibit(v, k));
    end

    // R7 R8 16-bit staged load and coherent read
    wr(A_CTRL, C_RUN | C_EXT);
    wr(A_HIGH, 8'h3C); wr(A_LOW, 8'h11);
    wr(A_HIGH, 8'h99);
    rd(A_HIGH, d); chk("R8 buffer holds staged", d, 8'h99);
    rd(A_LOW, d);  chk("R8 low loaded", d, 8'h11);
    rd(A_HIGH, d); chk("R8 buffer write did not reach counter", d, 8'h3C);
    for (int it = 0; it < 8; it++) begin
      h = 8'($urandom); l = 8'($urandom);
      wr(A_HIGH, h); wr(A_LOW, l); wr(A_HIGH, ~h);
      rd(A_LOW, d);  chk("R8 random low", d, l);
      rd(A_HIGH, d); chk("R7 random high", d, h);
    end
    wr(A_HIGH, 8'h12); wr(A_LOW, 8'hFF); settle();
    pin_pulses(1);
    rd(A_LOW, d);  chk("R7 carry low", d, 8'h00);
    rd(A_HIGH, d); chk("R7 carry high", d, 8'h13);
    rd(A_STAT, d); chk("R9 no flag on carry", d, 0);

    // R8 narrow low write keeps upper byte
    wr(A_HIGH, 8'h5A); wr(A_LOW, 8'h00);
    wr(A_CTRL, C_RUN | C_NAR | C_EXT);
    wr(A_HIGH, 8'hEE); wr(A_LOW, 8'h77);
    wr(A_CTRL, C_RUN | C_EXT);
    rd(A_LOW, d);  chk("R8 narrow low", d, 8'h77);
    rd(A_HIGH, d); chk("R8 narrow keeps high", d, 8'h5A);

    // R9 16-bit overflow
    wr(A_HIGH, 8'hFF); wr(A_LOW, 8'hFE); settle();
    pin_pulses(1);
    rd(A_STAT, d); chk("R9 no flag at FFFF", d, 0);
    pin_pulses(1);
    rd(A_STAT, d); chk("R9 wide flag", d, 1);
    chk("R9 irq pin", ovf_irq, 1);
    rd(A_LOW, d);  chk("R9 wide wrap low", d, 0);
    rd(A_HIGH, d); chk("R9 wide wrap high", d, 0);

    // R10 clear and write-one
    wr(A_STAT, 8'h01); rd(A_STAT, d); chk("R10 write one keeps", d, 1);
    wr(A_STAT, 8'h00); rd(A_STAT, d); chk("R10 clear", d, 0);
    wr(A_STAT, 8'h01); rd(A_STAT, d); chk("R10 write one no set", d, 0);

    // R9 8-bit overflow
    wr(A_CTRL, C_RUN | C_NAR | C_EXT);
    wr(A_LOW, 8'hFF); settle();
    pin_pulses(1);
    rd(A_STAT, d); chk("R9 narrow flag", d, 1);
    rd(A_LOW, d);  chk("R9 narrow wrap", d, 0);

    // R10 overflow and clear in the same cycle
    wr(A_LOW, 8'hFF); settle();
    @(negedge clk); cnt_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = A_STAT; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(A_STAT, d); chk("R10 set wins over clear", d, 1);
    rd(A_LOW, d);  chk("R10 wrap with clear", d, 0);
    cnt_pin = 1'b0; repeat (4) @(negedge clk);

    // R11 stopped
    wr(A_CTRL, C_NAR | C_EXT);
    wr(A_LOW, 8'h05); settle();
    pin_pulses(3);
    rd(A_LOW, d); chk("R11 pin stopped", d, 5);
    wr(A_CTRL, C_NAR);
    repeat (40) @(negedge clk);
    rd(A_LOW, d); chk("R11 timer stopped", d, 5);

    report();
    $finish;
  end
endmodule